// File: doc/BRIEF.md
# Two-Slot Execution List Scheduler

This block keeps the per-engine view of a two-slot execution list. A submission carries two context descriptors (element 0 and element 1), each with a valid flag, a privilege flag, a context id and a ring-context address. An accepted submission is stored in one of two list slots. From then on the block tracks which slot is running, whether the other slot is waiting as pending, and which element of the running slot is the running context. Schedule-out requests name the context that has just left the engine. The block moves the running context along in response and promotes the pending list when one exists.

Each transition is reported as one or two context-status events on a valid/ready port. Each event carries a set of kind flags, a context id and a flag that defers the interrupt. A 64-bit status word shows the slot pointers, the per-slot active and valid bits, queue-full and the running context id. Malformed or inconsistent requests produce a one-cycle error pulse and leave all state untouched. Requests are taken only while the event queue is empty. Requests offered while `rdy_o` is low are ignored.

Top module: `exl_sched`

## Requirements
- R1: After reset no slot is running and none is pending. `stat_o` is all zero, `evt_vld_o` and `err_o` are low, `rdy_o` is high, and the write pointer selects slot 0.
- R2: The following requests raise `err_o` for exactly one cycle and change neither the status nor the events: a submission whose element 0 is invalid, a submission with a valid element lacking privilege, or `sub_i` and `out_i` asserted together.
- R3: An accepted submission is written into the slot named by the status write pointer (bit 5). A submission while queue-full (bit 6) is set raises `err_o` and changes nothing.
- R4: A submission while nothing is running makes its slot running with element 0 as the running context and clears pending. It emits one event of kind idle-to-active (kind bit 0) with context id 0.
- R5: A submission while a slot is running takes over at once in two cases: (a) running element 1 is valid, equals the new element 0, and running element 0 is no longer the running context; (b) running element 1 is invalid and running element 0 equals the new element 0. The takeover emits one event with lite-restore (bit 5) and preempted (bit 1) set and the new element 0 id. Any other case only marks the new slot pending and emits no event.
- R6: Two descriptors are the same context only when both the context id and the ring-context address match.
- R7: A schedule-out that does not name the running context, or arrives while nothing is running, raises `err_o` and changes nothing.
- R8: A schedule-out of element 0 while running element 1 is valid moves the running context to element 1. It emits one event with context-complete (bit 4) and element-switch (bit 2) set and the outgoing id.
- R9: A schedule-out of the last valid element makes the pending slot running (element 0) or leaves the engine idle. It emits context-complete plus active-to-idle (bit 3) with the outgoing id. If a pending slot existed, that event has the defer flag set and is followed by an idle-to-active event with id 0 and defer clear.
- R10: Status layout: bits 0/1 are slot 0 valid/active and bits 2/3 are slot 1 valid/active, set only for the running slot. Bit 4 is the current pointer (running slot) and bit 5 is the write pointer (its inverse); both hold their value when the engine goes idle. Bit 6 is queue-full, equal to pending present. Bits 63:32 hold the running context id, or 0 when idle. All other bits are 0.
- R11: Events leave in order. A presented event holds its kind, id and defer flag until `evt_rdy_i` is high. While `rdy_o` is low, requests are ignored.
- R12: `err_o`, `stat_o` and the first event of a request are valid in the cycle after the clock edge that accepts the request. A second event follows in the cycle after the first is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rdy_o | output | 1 | High when a request will be taken |
| sub_i | input | 1 | Submission strobe |
| el0_vld_i | input | 1 | Element 0 valid |
| el0_priv_i | input | 1 | Element 0 privilege |
| el0_id_i | input | ID_W | Element 0 context id |
| el0_addr_i | input | AD_W | Element 0 ring-context address |
| el1_vld_i | input | 1 | Element 1 valid |
| el1_priv_i | input | 1 | Element 1 privilege |
| el1_id_i | input | ID_W | Element 1 context id |
| el1_addr_i | input | AD_W | Element 1 ring-context address |
| out_i | input | 1 | Schedule-out strobe |
| out_id_i | input | ID_W | Outgoing context id |
| out_addr_i | input | AD_W | Outgoing ring-context address |
| stat_o | output | 64 | Status word |
| evt_vld_o | output | 1 | Event valid |
| evt_rdy_i | input | 1 | Event taken |
| evt_kind_o | output | 6 | Event kind flags |
| evt_id_o | output | ID_W | Event context id |
| evt_defer_o | output | 1 | Interrupt for this event is deferred |
| err_o | output | 1 | Request rejected (one-cycle pulse) |

## Verification
Every request updates state at one edge. The bench drives strobes on the falling edge and reads `err_o`, `stat_o` and the head event on the next falling edge. That is one register stage after the accepting edge. The second event of a chained pair is read one falling edge later, after the first has been taken. An idle cycle is then allowed so the queue drains before the next request. The ignore test holds `evt_rdy_i` low. It offers a request while `rdy_o` is low and checks that the status and the held event are unchanged before releasing the port.

// File: rtl/exl_pkg.sv
package exl_pkg;
  localparam int unsigned NSLOT  = 2;
  localparam int unsigned NEL    = 2;
  localparam int unsigned NENT   = NSLOT * NEL;
  localparam int unsigned ENT_W  = $clog2(NENT);
  localparam int unsigned EVK_W  = 6;
  localparam int unsigned STAT_W = 64;
  localparam int unsigned ST_CUR  = 4;
  localparam int unsigned ST_WP   = 5;
  localparam int unsigned ST_FULL = 6;
  localparam int unsigned ST_ID   = 32;

  // bit 0 = to_act ... bit 5 = lite
  typedef struct packed {
    logic lite;
    logic done;
    logic to_idle;
    logic el_sw;
    logic preempt;
    logic to_act;
  } evk_t;
endpackage

// File: rtl/exl_decide.sv
module exl_decide
  import exl_pkg::*;
#(
  parameter int unsigned ID_W = 16,
  parameter int unsigned AD_W = 20,
  localparam int unsigned EVW = EVK_W + ID_W + 1
) (
  input  logic                       sub_i,
  input  logic                       out_i,
  input  logic                       el0_vld_i,
  input  logic                       el0_priv_i,
  input  logic [ID_W-1:0]            el0_id_i,
  input  logic [AD_W-1:0]            el0_addr_i,
  input  logic                       el1_vld_i,
  input  logic                       el1_priv_i,
  input  logic [ID_W-1:0]            el1_id_i,
  input  logic [AD_W-1:0]            el1_addr_i,
  input  logic [ID_W-1:0]            out_id_i,
  input  logic [AD_W-1:0]            out_addr_i,
  input  logic [NENT-1:0]            s_vld_i,
  input  logic [NENT-1:0][ID_W-1:0]  s_id_i,
  input  logic [NENT-1:0][AD_W-1:0]  s_ad_i,
  input  logic                       run_v_i,
  input  logic                       run_i_i,
  input  logic                       run_e_i,
  input  logic                       pend_v_i,
  input  logic                       pend_i_i,
  input  logic                       wr_p_i,
  output logic                       wr_o,
  output logic                       tgt_o,
  output logic                       run_v_o,
  output logic                       run_i_o,
  output logic                       run_e_o,
  output logic                       pend_v_o,
  output logic                       pend_i_o,
  output logic [1:0]                 n_ev_o,
  output logic [EVW-1:0]             ev0_o,
  output logic [EVW-1:0]             ev1_o,
  output logic                       err_o
);
  function automatic logic same(input logic [ID_W-1:0] ia, input logic [AD_W-1:0] aa,
                                input logic [ID_W-1:0] ib, input logic [AD_W-1:0] ab);
    return (ia == ib) && (aa == ab);
  endfunction

  logic [ENT_W-1:0] r0, r1, rc;
  logic             bad_sub, take_a, take_b;
  logic             out_hit, last_el, el_switch;
  evk_t             k0, k1;

  assign r0 = {run_i_i, 1'b0};
  assign r1 = {run_i_i, 1'b1};
  assign rc = {run_i_i, run_e_i};
  assign tgt_o = wr_p_i;

  assign bad_sub = !el0_vld_i || (el0_vld_i && !el0_priv_i) || (el1_vld_i && !el1_priv_i);

  assign take_a = s_vld_i[r1] && same(s_id_i[r1], s_ad_i[r1], el0_id_i, el0_addr_i)
                  && !same(s_id_i[r0], s_ad_i[r0], s_id_i[rc], s_ad_i[rc]);
  assign take_b = !s_vld_i[r1] && same(s_id_i[r0], s_ad_i[r0], el0_id_i, el0_addr_i);

  assign out_hit   = run_v_i && same(s_id_i[rc], s_ad_i[rc], out_id_i, out_addr_i);
  assign el_switch = s_vld_i[r1] && same(s_id_i[r0], s_ad_i[r0], out_id_i, out_addr_i);
  assign last_el   = (!s_vld_i[r1] && same(s_id_i[r0], s_ad_i[r0], out_id_i, out_addr_i))
                  || (s_vld_i[r1] && same(s_id_i[r1], s_ad_i[r1], out_id_i, out_addr_i));

  always_comb begin
    wr_o     = 1'b0;
    run_v_o  = run_v_i;
    run_i_o  = run_i_i;
    run_e_o  = run_e_i;
    pend_v_o = pend_v_i;
    pend_i_o = pend_i_i;
    n_ev_o   = 2'd0;
    err_o    = 1'b0;
    k0       = '0;
    k1       = '0;
    ev0_o    = '0;
    ev1_o    = '0;
    if (sub_i && out_i) begin
      err_o = 1'b1;
    end else if (sub_i) begin
      if (bad_sub || pend_v_i) begin
        err_o = 1'b1;
      end else begin
        wr_o = 1'b1;
        if (!run_v_i) begin
          run_v_o   = 1'b1;
          run_i_o   = tgt_o;
          run_e_o   = 1'b0;
          pend_v_o  = 1'b0;
          k0.to_act = 1'b1;
          n_ev_o    = 2'd1;
          ev0_o     = {k0, {ID_W{1'b0}}, 1'b0};
        end else if (take_a || take_b) begin
          run_i_o    = tgt_o;
          run_e_o    = 1'b0;
          pend_v_o   = 1'b0;
          k0.lite    = 1'b1;
          k0.preempt = 1'b1;
          n_ev_o     = 2'd1;
          ev0_o      = {k0, el0_id_i, 1'b0};
        end else begin
          pend_v_o = 1'b1;
          pend_i_o = tgt_o;
        end
      end
    end else if (out_i) begin
      if (!out_hit) begin
        err_o = 1'b1;
      end else if (el_switch) begin
        run_e_o  = 1'b1;
        k0.done  = 1'b1;
        k0.el_sw = 1'b1;
        n_ev_o   = 2'd1;
        ev0_o    = {k0, out_id_i, 1'b0};
      end else if (last_el) begin
        run_v_o    = pend_v_i;
        run_i_o    = pend_v_i ? pend_i_i : run_i_i;
        run_e_o    = 1'b0;
        pend_v_o   = 1'b0;
        k0.done    = 1'b1;
        k0.to_idle = 1'b1;
        ev0_o      = {k0, out_id_i, pend_v_i};
        if (pend_v_i) begin
          k1.to_act = 1'b1;
          ev1_o     = {k1, {ID_W{1'b0}}, 1'b0};
          n_ev_o    = 2'd2;
        end else begin
          n_ev_o    = 2'd1;
        end
      end else begin
        err_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/exl_evt_q.sv
module exl_evt_q #(
  parameter int unsigned EVW = 23
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_i,
  input  logic [1:0]     n_i,
  input  logic [EVW-1:0] e0_i,
  input  logic [EVW-1:0] e1_i,
  input  logic           rdy_i,
  output logic           vld_o,
  output logic [EVW-1:0] head_o,
  output logic           empty_o
);
  logic [1:0]     cnt_q;
  logic [EVW-1:0] q0_q, q1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= 2'd0;
      q0_q  <= '0;
      q1_q  <= '0;
    end else if (ld_i && (n_i != 2'd0)) begin
      cnt_q <= n_i;
      q0_q  <= e0_i;
      q1_q  <= e1_i;
    end else if ((cnt_q != 2'd0) && rdy_i) begin
      cnt_q <= cnt_q - 2'd1;
      q0_q  <= q1_q;
      q1_q  <= '0;
    end
  end

  assign vld_o   = (cnt_q != 2'd0);
  assign head_o  = q0_q;
  assign empty_o = (cnt_q == 2'd0);
endmodule

// File: rtl/exl_status.sv
module exl_status
  import exl_pkg::*;
#(
  parameter int unsigned ID_W = 16
) (
  input  logic              run_v_i,
  input  logic              run_i_i,
  input  logic              pend_v_i,
  input  logic              cur_p_i,
  input  logic              wr_p_i,
  input  logic [ID_W-1:0]   rc_id_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [2*NSLOT-1:0] sl_bits;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic SI = 1'(s);
    assign sl_bits[2*s]   = run_v_i && (run_i_i == SI);
    assign sl_bits[2*s+1] = run_v_i && (run_i_i == SI);
  end

  always_comb begin
    stat_o                           = '0;
    stat_o[2*NSLOT-1:0]              = sl_bits;
    stat_o[ST_CUR]                   = cur_p_i;
    stat_o[ST_WP]                    = wr_p_i;
    stat_o[ST_FULL]                  = pend_v_i;
    stat_o[ST_ID +: ID_W]            = run_v_i ? rc_id_i : '0;
  end
endmodule

// File: rtl/exl_sched.sv
module exl_sched
  import exl_pkg::*;
#(
  parameter int unsigned ID_W = 16,
  parameter int unsigned AD_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            rdy_o,
  input  logic            sub_i,
  input  logic            el0_vld_i,
  input  logic            el0_priv_i,
  input  logic [ID_W-1:0] el0_id_i,
  input  logic [AD_W-1:0] el0_addr_i,
  input  logic            el1_vld_i,
  input  logic            el1_priv_i,
  input  logic [ID_W-1:0] el1_id_i,
  input  logic [AD_W-1:0] el1_addr_i,
  input  logic            out_i,
  input  logic [ID_W-1:0] out_id_i,
  input  logic [AD_W-1:0] out_addr_i,
  output logic [63:0]     stat_o,
  output logic            evt_vld_o,
  input  logic            evt_rdy_i,
  output logic [5:0]      evt_kind_o,
  output logic [ID_W-1:0] evt_id_o,
  output logic            evt_defer_o,
  output logic            err_o
);
  localparam int unsigned EVW = EVK_W + ID_W + 1;

  logic [NENT-1:0]           s_vld_q;
  logic [NENT-1:0][ID_W-1:0] s_id_q;
  logic [NENT-1:0][AD_W-1:0] s_ad_q;
  logic run_v_q, run_i_q, run_e_q, pend_v_q, pend_i_q, cur_p_q, wr_p_q, err_q;

  logic           sub_a, out_a, wr, tgt;
  logic           run_v_d, run_i_d, run_e_d, pend_v_d, pend_i_d, err_d;
  logic [1:0]     n_ev;
  logic [EVW-1:0] ev0, ev1, head;
  logic           q_empty;

  assign rdy_o = q_empty;
  assign sub_a = sub_i && q_empty;
  assign out_a = out_i && q_empty;

  exl_decide #(.ID_W(ID_W), .AD_W(AD_W)) u_dec (
    .sub_i      (sub_a),
    .out_i      (out_a),
    .el0_vld_i  (el0_vld_i),
    .el0_priv_i (el0_priv_i),
    .el0_id_i   (el0_id_i),
    .el0_addr_i (el0_addr_i),
    .el1_vld_i  (el1_vld_i),
    .el1_priv_i (el1_priv_i),
    .el1_id_i   (el1_id_i),
    .el1_addr_i (el1_addr_i),
    .out_id_i   (out_id_i),
    .out_addr_i (out_addr_i),
    .s_vld_i    (s_vld_q),
    .s_id_i     (s_id_q),
    .s_ad_i     (s_ad_q),
    .run_v_i    (run_v_q),
    .run_i_i    (run_i_q),
    .run_e_i    (run_e_q),
    .pend_v_i   (pend_v_q),
    .pend_i_i   (pend_i_q),
    .wr_p_i     (wr_p_q),
    .wr_o       (wr),
    .tgt_o      (tgt),
    .run_v_o    (run_v_d),
    .run_i_o    (run_i_d),
    .run_e_o    (run_e_d),
    .pend_v_o   (pend_v_d),
    .pend_i_o   (pend_i_d),
    .n_ev_o     (n_ev),
    .ev0_o      (ev0),
    .ev1_o      (ev1),
    .err_o      (err_d)
  );

  // descriptor storage: entry index = {slot, element}
  for (genvar k = 0; k < NENT; k++) begin : g_ent
    localparam logic SL = 1'(k / NEL);
    localparam logic EL = 1'(k % NEL);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_vld_q[k] <= 1'b0;
        s_id_q[k]  <= '0;
        s_ad_q[k]  <= '0;
      end else if (wr && (tgt == SL)) begin
        s_vld_q[k] <= EL ? el1_vld_i  : el0_vld_i;
        s_id_q[k]  <= EL ? el1_id_i   : el0_id_i;
        s_ad_q[k]  <= EL ? el1_addr_i : el0_addr_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_v_q  <= 1'b0;
      run_i_q  <= 1'b0;
      run_e_q  <= 1'b0;
      pend_v_q <= 1'b0;
      pend_i_q <= 1'b0;
      cur_p_q  <= 1'b0;
      wr_p_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      run_v_q  <= run_v_d;
      run_i_q  <= run_i_d;
      run_e_q  <= run_e_d;
      pend_v_q <= pend_v_d;
      pend_i_q <= pend_i_d;
      err_q    <= err_d;
      if (run_v_d) begin
        cur_p_q <= run_i_d;
        wr_p_q  <= ~run_i_d;
      end
    end
  end

  exl_evt_q #(.EVW(EVW)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (sub_a || out_a),
    .n_i     (n_ev),
    .e0_i    (ev0),
    .e1_i    (ev1),
    .rdy_i   (evt_rdy_i),
    .vld_o   (evt_vld_o),
    .head_o  (head),
    .empty_o (q_empty)
  );

  exl_status #(.ID_W(ID_W)) u_st (
    .run_v_i  (run_v_q),
    .run_i_i  (run_i_q),
    .pend_v_i (pend_v_q),
    .cur_p_i  (cur_p_q),
    .wr_p_i   (wr_p_q),
    .rc_id_i  (s_id_q[{run_i_q, run_e_q}]),
    .stat_o   (stat_o)
  );

  assign evt_kind_o  = head[EVW-1 -: EVK_W];
  assign evt_id_o    = head[ID_W:1];
  assign evt_defer_o = head[0];
  assign err_o       = err_q;
endmodule

// File: rtl/exl_sched_chk.sv
module exl_sched_chk #(
  parameter int unsigned ID_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rdy_o,
  input logic            sub_i,
  input logic            out_i,
  input logic [63:0]     stat_o,
  input logic            evt_vld_o,
  input logic            evt_rdy_i,
  input logic [5:0]      evt_kind_o,
  input logic [ID_W-1:0] evt_id_o,
  input logic            evt_defer_o,
  input logic            err_o
);
  logic act0, act1;
  assign act0 = stat_o[1];
  assign act1 = stat_o[3];

  AST_ONE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({act0, act1})); // R10
  AST_FULL_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[6] |-> (act0 || act1)); // R10
  AST_PTR_INVERSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act0 || act1) |-> (stat_o[4] != stat_o[5])); // R10
  AST_IDLE_ID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act0 || act1) |-> (stat_o[63:32] == 32'd0)); // R10
  AST_ERR_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(stat_o) && !evt_vld_o)); // R2
  AST_EVT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_o && !evt_rdy_i) |=> (evt_vld_o && $stable(evt_kind_o)
                                   && $stable(evt_id_o) && $stable(evt_defer_o))); // R11
  AST_IGNORE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && (sub_i || out_i)) |=> ($stable(stat_o) && !err_o)); // R11
  AST_DEFER_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_o && evt_rdy_i && evt_defer_o) |=>
      (evt_vld_o && (evt_kind_o == 6'h01) && !evt_defer_o && (evt_id_o == '0))); // R9
endmodule

bind exl_sched exl_sched_chk #(.ID_W(ID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rdy_o       (rdy_o),
  .sub_i       (sub_i),
  .out_i       (out_i),
  .stat_o      (stat_o),
  .evt_vld_o   (evt_vld_o),
  .evt_rdy_i   (evt_rdy_i),
  .evt_kind_o  (evt_kind_o),
  .evt_id_o    (evt_id_o),
  .evt_defer_o (evt_defer_o),
  .err_o       (err_o)
);

// File: tb/exl_sched_bench.sv
`timescale 1ns/1ps
module exl_sched_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic        rdy_o, sub_i, out_i, evt_vld_o, evt_rdy_i, evt_defer_o, err_o;
  logic        el0_vld_i, el0_priv_i, el1_vld_i, el1_priv_i;
  logic [15:0] el0_id_i, el1_id_i, out_id_i, evt_id_o;
  logic [19:0] el0_addr_i, el1_addr_i, out_addr_i;
  logic [63:0] stat_o;
  logic [5:0]  evt_kind_o;

  exl_sched #(.ID_W(16), .AD_W(20)) u_exl_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .rdy_o(rdy_o), .sub_i(sub_i),
    .el0_vld_i(el0_vld_i), .el0_priv_i(el0_priv_i), .el0_id_i(el0_id_i), .el0_addr_i(el0_addr_i),
    .el1_vld_i(el1_vld_i), .el1_priv_i(el1_priv_i), .el1_id_i(el1_id_i), .el1_addr_i(el1_addr_i),
    .out_i(out_i), .out_id_i(out_id_i), .out_addr_i(out_addr_i), .stat_o(stat_o),
    .evt_vld_o(evt_vld_o), .evt_rdy_i(evt_rdy_i), .evt_kind_o(evt_kind_o), .evt_id_o(evt_id_o),
    .evt_defer_o(evt_defer_o), .err_o(err_o)
  );

  int checks = 0;
  int failures = 0;

  // op: 1 submit, 2 schedule-out (uses id0/a0), 3 both strobes
  typedef struct packed {
    logic [1:0]  op;
    logic        v0, p0; logic [15:0] id0; logic [19:0] a0;
    logic        v1, p1; logic [15:0] id1; logic [19:0] a1;
    logic        err;    logic [1:0]  nev;
    logic [5:0]  k0; logic [15:0] i0; logic d0;
    logic [5:0]  k1; logic [15:0] i1; logic d1;
    logic [3:0]  sb; logic cur, wp, full; logic [15:0] sid;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    // R4: idle submit A,B -> slot 0 runs
    '{2'd1, 1'b1,1'b1,16'h0011,20'h00100, 1'b1,1'b1,16'h0022,20'h00200, 1'b0,2'd1, 6'h01,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'h3,1'b0,1'b1,1'b0,16'h0011},
    // R5: no takeover -> pending slot 1
    '{2'd1, 1'b1,1'b1,16'h0033,20'h00300, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd0, 6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'h3,1'b0,1'b1,1'b1,16'h0011},
    // R3: queue full
    '{2'd1, 1'b1,1'b1,16'h0033,20'h00300, 1'b0,1'b0,16'h0000,20'h00000, 1'b1,2'd0, 6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'h3,1'b0,1'b1,1'b1,16'h0011},
    // R7: out of non-running context
    '{2'd2, 1'b0,1'b0,16'h0022,20'h00200, 1'b0,1'b0,16'h0000,20'h00000, 1'b1,2'd0, 6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'h3,1'b0,1'b1,1'b1,16'h0011},
    // R8: element switch
    '{2'd2, 1'b0,1'b0,16'h0011,20'h00100, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd1, 6'h14,16'h0011,1'b0, 6'h00,16'h0000,1'b0, 4'h3,1'b0,1'b1,1'b1,16'h0022},
    // R9: last element with pending -> chained pair
    '{2'd2, 1'b0,1'b0,16'h0022,20'h00200, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd2, 6'h18,16'h0022,1'b1, 6'h01,16'h0000,1'b0, 4'hC,1'b1,1'b0,1'b0,16'h0033},
    // R5: case b takeover
    '{2'd1, 1'b1,1'b1,16'h0033,20'h00300, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd1, 6'h22,16'h0033,1'b0, 6'h00,16'h0000,1'b0, 4'h3,1'b0,1'b1,1'b0,16'h0033},
    // R6: same id, other address -> not same, pending
    '{2'd1, 1'b1,1'b1,16'h0033,20'h00301, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd0, 6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'h3,1'b0,1'b1,1'b1,16'h0033},
    // R9: last element, pending promoted
    '{2'd2, 1'b0,1'b0,16'h0033,20'h00300, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd2, 6'h18,16'h0033,1'b1, 6'h01,16'h0000,1'b0, 4'hC,1'b1,1'b0,1'b0,16'h0033},
    // R9/R10: last element, no pending -> idle, pointers hold
    '{2'd2, 1'b0,1'b0,16'h0033,20'h00301, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd1, 6'h18,16'h0033,1'b0, 6'h00,16'h0000,1'b0, 4'h0,1'b1,1'b0,1'b0,16'h0000},
    // R2: element 0 invalid
    '{2'd1, 1'b0,1'b1,16'h0011,20'h00100, 1'b1,1'b1,16'h0022,20'h00200, 1'b1,2'd0, 6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'h0,1'b1,1'b0,1'b0,16'h0000},
    // R2: element 0 lacks privilege
    '{2'd1, 1'b1,1'b0,16'h0011,20'h00100, 1'b0,1'b0,16'h0000,20'h00000, 1'b1,2'd0, 6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'h0,1'b1,1'b0,1'b0,16'h0000},
    // R2: element 1 valid without privilege
    '{2'd1, 1'b1,1'b1,16'h0011,20'h00100, 1'b1,1'b0,16'h0022,20'h00200, 1'b1,2'd0, 6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'h0,1'b1,1'b0,1'b0,16'h0000},
    // R3/R4: idle submit goes to write pointer slot 0
    '{2'd1, 1'b1,1'b1,16'h0044,20'h00400, 1'b1,1'b1,16'h0011,20'h00100, 1'b0,2'd1, 6'h01,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'h3,1'b0,1'b1,1'b0,16'h0044},
    // R8
    '{2'd2, 1'b0,1'b0,16'h0044,20'h00400, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd1, 6'h14,16'h0044,1'b0, 6'h00,16'h0000,1'b0, 4'h3,1'b0,1'b1,1'b0,16'h0011},
    // R5: case a takeover
    '{2'd1, 1'b1,1'b1,16'h0011,20'h00100, 1'b1,1'b1,16'h0022,20'h00200, 1'b0,2'd1, 6'h22,16'h0011,1'b0, 6'h00,16'h0000,1'b0, 4'hC,1'b1,1'b0,1'b0,16'h0011},
    // R5: ctx1 valid but differs -> pending
    '{2'd1, 1'b1,1'b1,16'h0011,20'h00100, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd0, 6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'hC,1'b1,1'b0,1'b1,16'h0011},
    // R6/R7: out with matching id but other address
    '{2'd2, 1'b0,1'b0,16'h0011,20'h00101, 1'b0,1'b0,16'h0000,20'h00000, 1'b1,2'd0, 6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'hC,1'b1,1'b0,1'b1,16'h0011}
  };

  function automatic logic [63:0] exp_stat(input logic [3:0] sb, input logic cur, wp, full,
                                           input logic [15:0] sid);
    return {16'h0, sid, 25'h0, full, wp, cur, sb};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk_i);
    sub_i = v.op[0];
    out_i = v.op[1];
    el0_vld_i = v.v0; el0_priv_i = v.p0; el0_id_i = v.id0; el0_addr_i = v.a0;
    el1_vld_i = v.v1; el1_priv_i = v.p1; el1_id_i = v.id1; el1_addr_i = v.a1;
    out_id_i = v.id0; out_addr_i = v.a0;
    @(negedge clk_i);
    sub_i = 1'b0;
    out_i = 1'b0;
  endtask

  // R12: results one edge after acceptance, second event one edge later
  task automatic run_vec(input vec_t v, input string tag);
    drive(v);
    chk({tag, " R12 err"}, 64'(err_o), 64'(v.err));
    chk({tag, " R10 stat"}, stat_o, exp_stat(v.sb, v.cur, v.wp, v.full, v.sid));
    if (v.nev != 2'd0)
      chk({tag, " R11 ev0"}, {evt_vld_o, evt_kind_o, evt_id_o, evt_defer_o},
          {1'b1, v.k0, v.i0, v.d0});
    else
      chk({tag, " R11 no ev"}, 64'(evt_vld_o), 64'd0);
    @(negedge clk_i);
    chk({tag, " R2 err pulse"}, 64'(err_o), 64'd0);
    if (v.nev == 2'd2)
      chk({tag, " R9 ev1"}, {evt_vld_o, evt_kind_o, evt_id_o, evt_defer_o},
          {1'b1, v.k1, v.i1, v.d1});
    else
      chk({tag, " R11 drained"}, 64'(evt_vld_o), 64'd0);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    sub_i = 1'b0; out_i = 1'b0; evt_rdy_i = 1'b1;
    el0_vld_i = 1'b0; el0_priv_i = 1'b0; el0_id_i = '0; el0_addr_i = '0;
    el1_vld_i = 1'b0; el1_priv_i = 1'b0; el1_id_i = '0; el1_addr_i = '0;
    out_id_i = '0; out_addr_i = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 stat", stat_o, 64'd0);
    chk("R1 flags", {61'd0, evt_vld_o, err_o, rdy_o}, 64'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) run_vec(VT[i], $sformatf("vec%0d", i));

    // R11: event held and requests ignored while port stalled
    evt_rdy_i = 1'b0;
    drive('{2'd2, 1'b0,1'b0,16'h0011,20'h00100, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd1,
            6'h14,16'h0011,1'b0, 6'h00,16'h0000,1'b0, 4'hC,1'b1,1'b0,1'b1,16'h0022});
    chk("R8 stalled ev", {evt_vld_o, evt_kind_o, evt_id_o, evt_defer_o}, {1'b1, 6'h14, 16'h0011, 1'b0});
    chk("R11 rdy low", 64'(rdy_o), 64'd0);
    drive('{2'd2, 1'b0,1'b0,16'h0022,20'h00200, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd0,
            6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'hC,1'b1,1'b0,1'b1,16'h0022});
    chk("R11 ignored stat", stat_o, exp_stat(4'hC, 1'b1, 1'b0, 1'b1, 16'h0022));
    chk("R11 ignored err", 64'(err_o), 64'd0);
    chk("R11 held ev", {evt_vld_o, evt_kind_o, evt_id_o, evt_defer_o}, {1'b1, 6'h14, 16'h0011, 1'b0});
    evt_rdy_i = 1'b1;
    @(negedge clk_i);
    chk("R11 popped", {62'd0, evt_vld_o, rdy_o}, 64'd1);

    // R2: both strobes
    run_vec('{2'd3, 1'b1,1'b1,16'h0022,20'h00200, 1'b0,1'b0,16'h0000,20'h00000, 1'b1,2'd0,
              6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'hC,1'b1,1'b0,1'b1,16'h0022}, "R2 both");
    // R9: last element promotes pending slot 0
    run_vec('{2'd2, 1'b0,1'b0,16'h0022,20'h00200, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd2,
              6'h18,16'h0022,1'b1, 6'h01,16'h0000,1'b0, 4'h3,1'b0,1'b1,1'b0,16'h0011}, "R9 chain");
    run_vec('{2'd2, 1'b0,1'b0,16'h0011,20'h00100, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd1,
              6'h18,16'h0011,1'b0, 6'h00,16'h0000,1'b0, 4'h0,1'b0,1'b1,1'b0,16'h0000}, "R9 idle");
    // R7: out while idle
    run_vec('{2'd2, 1'b0,1'b0,16'h0011,20'h00100, 1'b0,1'b0,16'h0000,20'h00000, 1'b1,2'd0,
              6'h00,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'h0,1'b0,1'b1,1'b0,16'h0000}, "R7 idle");

    // R1: reset mid-run restores write pointer to slot 0
    run_vec('{2'd1, 1'b1,1'b1,16'h0055,20'h00500, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd1,
              6'h01,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'hC,1'b1,1'b0,1'b0,16'h0055}, "R4 slot1");
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 reset stat", stat_o, 64'd0);
    chk("R1 reset flags", {61'd0, evt_vld_o, err_o, rdy_o}, 64'd1);
    rst_ni = 1'b1;
    run_vec('{2'd1, 1'b1,1'b1,16'h0044,20'h00400, 1'b0,1'b0,16'h0000,20'h00000, 1'b0,2'd1,
              6'h01,16'h0000,1'b0, 6'h00,16'h0000,1'b0, 4'h3,1'b0,1'b1,1'b0,16'h0044}, "R3 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule